// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 12-bit successive-approximation converter. A host starts a conversion by pulling chip select and read low while the high-byte select is low. The block then clears its approximation register and turns on the data output drivers. It then walks a trial code through an external capacitive DAC, one binary weight at a time, starting from the top bit. On each falling edge of a separate conversion clock it keeps or drops the current trial bit according to a one-bit comparator result.

After the last bit is decided, the finished word moves into an output latch and a one-cycle completion pulse is issued. A programmable hold-off then keeps the next start from being accepted until the analog input has had time to settle again. An 8-bit data port presents either the low byte or the zero-extended upper nibble of the latched word. Which one it shows depends on the high-byte select.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A start is recognised only in the cycle where chip_sel_n, read_n and hi_byte first become all low together. The combination held low does not retrigger, and the combination with hi_byte high does not start a conversion.
- R2: An accepted start raises busy on the next clock edge, clears the approximation register (dac_code reads 0 while waiting for the first decision), and asserts data_oe. data_oe is also high whenever chip_sel_n and read_n are both low.
- R3: A start request made while busy is high has no effect: the running conversion is neither aborted nor restarted, and its result is unchanged.
- R4: During the decision phase, dac_code equals the bits already decided plus a single trial 1 at the bit under test. The trial moves from bit 11 down to bit 0.
- R5: The bit 11 decision is taken on the second falling edge of conv_clk after the start, and each lower bit on each following falling edge. Between falling edges dac_code does not change.
- R6: A trial bit is kept when cmp_in is 1 (DAC level at or below the input) and cleared when cmp_in is 0.
- R7: On the edge of the bit 0 decision, the word is loaded into the output latch, busy falls, and done is high for exactly one cycle.
- R8: A start is ignored until GAP_CYC clock cycles have passed after the cycle in which done was high.
- R9: With hi_byte high, data_out is {4'b0000, result[11:8]}. With hi_byte low, it is result[7:0].
- R10: With an ideal comparator, the latched result equals the input code for every code from 0 to 4095.
- R11: After reset, busy, done and dac_code are 0 and the latched result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_sel_n | input | 1 | Active-low chip select |
| read_n | input | 1 | Active-low read strobe |
| hi_byte | input | 1 | Byte select for data_out; must be low for a start |
| conv_clk | input | 1 | Conversion clock; decisions occur on its falling edges |
| cmp_in | input | 1 | Comparator: 1 when DAC level is at or below the input |
| dac_code | output | 12 | Trial code driven to the capacitive DAC |
| busy | output | 1 | High from accepted start until the result is latched |
| done | output | 1 | One-cycle pulse at the latch update |
| data_oe | output | 1 | Enable for the three-state data drivers |
| data_out | output | 8 | Selected byte of the latched result |

## Verification
A wrong bit index or a wrong decision shows up on dac_code at the very next falling edge of conv_clk. The reference model predicts that code on every cycle. A miscounted wait before the first decision shifts the whole trial sequence by one conversion-clock period, and it is caught within two cycles of the expected first trial. A stale gap counter or a lost start edge shows on busy within one cycle of the start strobe. A corrupted latch shows on data_out in the cycle that done is high, and the sweep over all 4096 codes covers both byte views.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_start.sv
module sar_start #(
  parameter int GAP_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel_n,
  input  logic read_n,
  input  logic hi_byte,
  input  logic busy,
  input  logic finish,
  output logic start_acc
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  logic             req, req_q, req_rise;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             gap_en;

  assign req      = ~chip_sel_n & ~read_n & ~hi_byte;
  assign req_rise = req & ~req_q;
  assign start_acc = req_rise & ~busy & (gap_q == '0);

  always_comb begin
    gap_en = finish | (gap_q != '0);
    gap_d  = finish ? GAP_W'(GAP_CYC) : gap_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      gap_q <= '0;
    end else begin
      req_q <= req;
      if (gap_en) gap_q <= gap_d;
    end
  end

  assert_single_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> !start_acc);
endmodule

// File: rtl/sar_seq.sv
module sar_seq import sar_pkg::*; #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_acc,
  input  logic                conv_clk,
  input  logic                cmp_in,
  output logic                busy,
  output logic                finish,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] result_nxt
);
  localparam int IDX_W = $clog2(RES_BITS);

  sar_state_e          st_q, st_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [RES_BITS-1:0] sar_q, sar_d, trial;
  logic                cclk_q, fall, step_en;

  assign fall    = cclk_q & ~conv_clk;
  assign step_en = start_acc | fall;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    sar_d = sar_q;
    case (st_q)
      ST_IDLE: if (start_acc) begin
        st_d  = ST_WAIT;
        sar_d = '0;
        idx_d = IDX_W'(RES_BITS - 1);
      end
      ST_WAIT: if (fall) st_d = ST_CONV;
      ST_CONV: if (fall) begin
        sar_d[idx_q] = cmp_in;
        if (idx_q == '0) st_d = ST_IDLE;
        else             idx_d = idx_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    trial = '0;
    if (st_q == ST_CONV) trial[idx_q] = 1'b1;
  end

  assign dac_code   = sar_q | trial;
  assign busy       = (st_q != ST_IDLE);
  assign finish     = (st_q == ST_CONV) & fall & (idx_q == '0);
  assign result_nxt = sar_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      sar_q  <= '0;
      cclk_q <= 1'b0;
    end else begin
      cclk_q <= conv_clk;
      if (step_en) begin
        st_q  <= st_d;
        idx_q <= idx_d;
        sar_q <= sar_d;
      end
    end
  end

  assert_clear_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sar_q == '0));
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (idx_q <= $past(idx_q)));
  assert_hold_between_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fall)) |-> ($stable(sar_q) && $stable(idx_q)));
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int RES_BITS = 12,
  parameter int BYTE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                finish,
  input  logic [RES_BITS-1:0] result_nxt,
  input  logic                hi_byte,
  output logic                done,
  output logic [BYTE_W-1:0]   data_out
);
  localparam int HI_W = RES_BITS - BYTE_W;

  logic [RES_BITS-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (finish) word_q <= result_nxt;
    end
  end

  assign data_out = hi_byte ? {{(BYTE_W - HI_W){1'b0}}, word_q[RES_BITS-1:BYTE_W]}
                            : word_q[BYTE_W-1:0];

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int RES_BITS = 12,
  parameter int BYTE_W   = 8,
  parameter int GAP_CYC  = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chip_sel_n,
  input  logic                read_n,
  input  logic                hi_byte,
  input  logic                conv_clk,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] dac_code,
  output logic                busy,
  output logic                done,
  output logic                data_oe,
  output logic [BYTE_W-1:0]   data_out
);
  logic [1:0]          rsync_q;
  logic                rst_ni;
  logic                start_acc, finish;
  logic [RES_BITS-1:0] result_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  sar_start #(.GAP_CYC(GAP_CYC)) u_start (
    .clk(clk), .rst_n(rst_ni), .chip_sel_n(chip_sel_n), .read_n(read_n),
    .hi_byte(hi_byte), .busy(busy), .finish(finish), .start_acc(start_acc));

  sar_seq #(.RES_BITS(RES_BITS)) u_seq (
    .clk(clk), .rst_n(rst_ni), .start_acc(start_acc), .conv_clk(conv_clk),
    .cmp_in(cmp_in), .busy(busy), .finish(finish), .dac_code(dac_code),
    .result_nxt(result_nxt));

  sar_result #(.RES_BITS(RES_BITS), .BYTE_W(BYTE_W)) u_res (
    .clk(clk), .rst_n(rst_ni), .finish(finish), .result_nxt(result_nxt),
    .hi_byte(hi_byte), .done(done), .data_out(data_out));

  assign data_oe = busy | (~chip_sel_n & ~read_n);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> !busy);
  assert_gap_after_done_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !busy);
endmodule

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
  localparam int GAP_T = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_sel_n = 1'b1, read_n = 1'b1, hi_byte = 1'b0, conv_clk = 1'b0;
  logic        cmp_in;
  logic [11:0] ain = 12'd0;
  logic [11:0] dac_code;
  logic        busy, done, data_oe;
  logic [7:0]  data_out;

  int checks = 0, errors = 0, cycles = 0;

  sar_conv_ctrl #(.RES_BITS(12), .BYTE_W(8), .GAP_CYC(GAP_T)) uut (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .read_n(read_n),
    .hi_byte(hi_byte), .conv_clk(conv_clk), .cmp_in(cmp_in), .dac_code(dac_code),
    .busy(busy), .done(done), .data_oe(data_oe), .data_out(data_out));

  assign cmp_in = (dac_code <= ain);

  always #5 clk = ~clk;
  always @(negedge clk) conv_clk <= #1 ~conv_clk;

  // behavioural reference model
  int m_ph = 0, m_idx = 0, m_sar = 0, m_latch = 0, m_gap = 0, m_rc = 0;
  bit m_done = 0, m_pst = 0, m_pcc = 0;

  function automatic int exp_dac();
    return m_sar | ((m_ph == 2) ? (1 << m_idx) : 0);
  endfunction

  always @(posedge clk) begin
    bit st, fl, cv, fin;
    if (!rst_n || m_rc < 2) begin
      if (!rst_n) m_rc = 0; else m_rc++;
      m_ph = 0; m_idx = 0; m_sar = 0; m_latch = 0; m_gap = 0;
      m_done = 0; m_pst = 0; m_pcc = 0;
    end else begin
      st  = !chip_sel_n && !read_n && !hi_byte;
      fl  = m_pcc && !conv_clk;
      cv  = (exp_dac() <= int'(ain));
      fin = 0;
      m_done = 0;
      if (m_ph == 0) begin
        if (st && !m_pst && m_gap == 0) begin m_ph = 1; m_sar = 0; m_idx = 11; end
      end else if (m_ph == 1) begin
        if (fl) m_ph = 2;
      end else if (fl) begin
        if (cv) m_sar = m_sar | (1 << m_idx);
        if (m_idx == 0) begin m_ph = 0; fin = 1; m_latch = m_sar; m_done = 1; end
        else m_idx--;
      end
      if (fin) m_gap = GAP_T; else if (m_gap > 0) m_gap--;
      m_pst = st;
      m_pcc = conv_clk;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && m_rc >= 2) begin
      chk("R4 R5 R6 dac_code", int'(dac_code), exp_dac());
      chk("R1 R2 R3 R7 busy", int'(busy), int'(m_ph != 0));
      chk("R7 done", int'(done), int'(m_done));
      chk("R2 data_oe", int'(data_oe), int'((m_ph != 0) || (!chip_sel_n && !read_n)));
      chk("R9 data_out", int'(data_out), hi_byte ? (m_latch >> 8) : (m_latch & 255));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #2; end
  endtask

  task automatic pulse_start();
    chip_sel_n = 1'b0; read_n = 1'b0; tick(1); read_n = 1'b1;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
    #2;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R11: reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 dac_code", int'(dac_code), 0);
    chk("R11 data_out", int'(data_out), 0);

    // R1: hi_byte high blocks a start
    hi_byte = 1'b1; chip_sel_n = 1'b0; read_n = 1'b0; tick(3);
    chk("R1 no start with hi_byte", int'(busy), 0);
    read_n = 1'b1; hi_byte = 1'b0; tick(2);

    // R3: restart attempt mid conversion
    ain = 12'hA5C;
    pulse_start();
    chk("R2 busy after start", int'(busy), 1);
    tick(6);
    pulse_start();
    wait_done();
    chk("R3 result low byte", int'(data_out), 'h5C);
    hi_byte = 1'b1; tick(1);
    chk("R9 R3 result high byte", int'(data_out), 'h0A);
    hi_byte = 1'b0;

    // R8: start during the hold-off is ignored
    ain = 12'h3F1;
    pulse_start();
    tick(1);
    chk("R8 start in gap ignored", int'(busy), 0);
    tick(GAP_T + 1);
    pulse_start();
    chk("R8 start after gap", int'(busy), 1);
    wait_done();
    chk("R6 result", int'(data_out), 'hF1);

    // R1: held request does not retrigger
    tick(GAP_T + 1);
    ain = 12'h800;
    chip_sel_n = 1'b0; read_n = 1'b0;
    wait_done();
    tick(GAP_T + 6);
    chk("R1 held request no retrigger", int'(busy), 0);
    read_n = 1'b1; tick(GAP_T + 1);

    // R10: sweep over every code
    for (int c = 0; c < 4096; c++) begin
      ain = 12'(c);
      pulse_start();
      wait_done();
      chk("R10 R6 sweep low", int'(data_out), c & 255);
      hi_byte = 1'b1; tick(1);
      chk("R10 R9 sweep high", int'(data_out), c >> 8);
      hi_byte = 1'b0;
      tick(GAP_T);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule